// File: doc/BRIEF.md
# Memory-in-Pixel Panel Timing Generator

This block drives the control pins of a memory-in-pixel parallel display panel for one frame at a time. A one-cycle `frame_start` pulse starts a sequence on the timing clock. The sequence raises a panel reset pulse and a vertical-start window, then runs a vertical clock whose half periods each carry one horizontal line. The line itself is a run of horizontal clock half periods. Within each line the block also places a horizontal-start window, a data strobe for every horizontal transfer, and an enable pulse on a chosen range of lines.

All timing values are static input ports. Pixel fetching, format conversion and register access are handled elsewhere; a downstream pixel path only needs `xfer_strobe` to know when to present the next pair of pixels. The sizes follow from the panel: the vertical transfer count is twice the panel line count, and the horizontal transfer count is half the pixel count of a line. Settings that cannot work, such as a half-period length below 2 or an empty line, are not used.

Cycle numbering used below: cycle 0 is the first clock cycle after the rising edge that accepts `frame_start`. H = `hck_half`, L = `h_front + h_xfers + h_back` (HCK half periods per line) and N = `v_front + v_xfers + v_back` (VCK half periods per frame). For a cycle k ≥ `vck_delay`, let m = k − `vck_delay`. The HCK half-period count is then q = m / H, the VCK half-period index is v = q / L, the half-period index inside the line is p = q mod L, and the cycle inside the line is c = m mod (H·L).

Top module: `pnl_timing_gen`

## Requirements
- R1: From cycle `vck_delay` until the frame ends, `pnl_hck` changes every H cycles without a break across line boundaries, and is high while q is even; `hck_half` must be at least 2.
- R2: `pnl_rst` is high in cycles 0 to `rst_width`−1 of the frame and low otherwise.
- R3: `pnl_vst` is high in cycles k with `vst_delay` ≤ k < `vst_delay`+`vst_width` while the frame runs.
- R4: `pnl_vck` rises in cycle `vck_delay`, changes every H·L cycles, and is high while v is even, for N half periods in all.
- R5: `pnl_hst` is high when `hst_delay` ≤ c < `hst_delay`+`hst_width`, after every VCK transition including blanking lines.
- R6: `xfer_strobe` is high for exactly the first cycle of each half period with `h_front` ≤ p < `h_front`+`h_xfers`, only when `v_front` ≤ v < `v_front`+`v_xfers`.
- R7: `pnl_enb` is high on transfer line number v−`v_front` when that number lies in `enb_first`..`enb_last` inclusive, during the half periods with `enb_start` ≤ p < `enb_start`+`enb_width`.
- R8: `busy` is high from cycle 0 through cycle `vck_delay`+N·H·L−1 and low afterwards. A `frame_start` that arrives while `busy` is high is ignored, including in the last busy cycle.
- R9: While `soft_rst` is high, all panel outputs and `busy` are low from the next cycle on, `soft_rst_active` is high one cycle after `soft_rst`, and `frame_start` is ignored.
- R10: During and right after `rst_n` reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of the timing sequence |
| frame_start | input | 1 | Start request for one frame |
| hck_half | input | CW | HCK half period in cycles (≥ 2) |
| rst_width | input | CW | Panel reset pulse width in cycles |
| vst_delay | input | CW | Cycles from frame start to VST |
| vst_width | input | CW | VST width in cycles |
| vck_delay | input | CW | Cycles from frame start to first VCK edge |
| hst_delay | input | CW | Cycles from a VCK edge to HST |
| hst_width | input | CW | HST width in cycles |
| h_front | input | CW | Horizontal front blanking, HCK half periods |
| h_xfers | input | CW | Horizontal transfers per line |
| h_back | input | CW | Horizontal back blanking, HCK half periods |
| v_front | input | CW | Vertical front blanking, VCK half periods |
| v_xfers | input | CW | Vertical transfers per frame |
| v_back | input | CW | Vertical back blanking, VCK half periods |
| enb_first | input | CW | First transfer line with ENB |
| enb_last | input | CW | Last transfer line with ENB |
| enb_start | input | CW | HCK half periods from VCK edge to ENB |
| enb_width | input | CW | ENB width in HCK half periods |
| pnl_rst | output | 1 | Panel reset pulse |
| pnl_vst | output | 1 | Vertical start |
| pnl_vck | output | 1 | Vertical clock |
| pnl_hst | output | 1 | Horizontal start |
| pnl_hck | output | 1 | Horizontal clock |
| pnl_enb | output | 1 | Panel enable |
| xfer_strobe | output | 1 | One-cycle strobe per horizontal transfer |
| busy | output | 1 | Frame sequence in progress |
| soft_rst_active | output | 1 | Soft reset status |

## Verification
Two pairs of events can fall in the same cycle: the end of a frame with a new start request, and a soft reset with a start request. The bench raises `frame_start` in the last busy cycle of a frame. It expects that request to be dropped, so `busy` must be low the next cycle and stay low. It also holds `frame_start` high while `soft_rst` is high, and expects `busy` to stay low after the soft reset is released. Every cycle of each frame is compared against a model computed from the cycle-numbering formulas.

// File: rtl/pnl_timing_pkg.sv
package pnl_timing_pkg;
  localparam int WIN_W = 48;

  // true when pos lies in [first, first+len)
  function automatic logic in_win(input logic [WIN_W-1:0] pos,
                                  input logic [WIN_W-1:0] first,
                                  input logic [WIN_W-1:0] len);
    return (pos >= first) && (pos < first + len);
  endfunction
endpackage

// File: rtl/pnl_frame_seq.sv
module pnl_frame_seq
  import pnl_timing_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          frame_start,
  input  logic          vact,
  input  logic          done,
  input  logic [CW-1:0] rst_width,
  input  logic [CW-1:0] vst_delay,
  input  logic [CW-1:0] vst_width,
  input  logic [CW-1:0] vck_delay,
  output logic          busy,
  output logic          enter,
  output logic          xrst,
  output logic          vst,
  output logic          srst_flag
);
  localparam int FW1 = FW + 1;

  logic [FW-1:0] cnt;
  logic [FW:0]   cnt_inc;
  logic          accept;

  assign accept  = frame_start && !busy && !soft_rst;
  assign cnt_inc = {1'b0, cnt} + FW1'(1);
  assign enter   = (accept && vck_delay == '0) ||
                   (busy && !vact && cnt_inc == FW1'(vck_delay));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      srst_flag <= 1'b0;
    end else begin
      srst_flag <= soft_rst;
      if (soft_rst) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else begin
        if (done) busy <= 1'b0;
        if (busy && cnt != '1) cnt <= cnt + FW'(1);
      end
    end
  end

  assign xrst = busy && in_win(WIN_W'(cnt), '0, WIN_W'(rst_width));
  assign vst  = busy && in_win(WIN_W'(cnt), WIN_W'(vst_delay), WIN_W'(vst_width));

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    busy && frame_start && !done |=> busy);

  // R9
  soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && srst_flag);
endmodule

// File: rtl/pnl_raster.sv
module pnl_raster #(
  parameter int CW = 16,
  parameter int PW = CW + 2,
  parameter int LW = 2 * CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          enter,
  input  logic [CW-1:0] hck_half,
  input  logic [PW-1:0] line_hp,
  input  logic [PW-1:0] n_vhp,
  output logic          vact,
  output logic [CW-1:0] sub_q,
  output logic [PW-1:0] hp_q,
  output logic [PW-1:0] vhp_q,
  output logic [LW-1:0] lc_q,
  output logic          hck_q,
  output logic          vck_q,
  output logic          done
);
  logic last_sub, last_hp, last_v;

  assign last_sub = (sub_q == hck_half - CW'(1));
  assign last_hp  = (hp_q  == line_hp  - PW'(1));
  assign last_v   = (vhp_q == n_vhp    - PW'(1));
  assign done     = vact && last_sub && last_hp && last_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vact <= 1'b0; sub_q <= '0; hp_q <= '0; vhp_q <= '0; lc_q <= '0;
      hck_q <= 1'b0; vck_q <= 1'b0;
    end else if (soft_rst) begin
      vact <= 1'b0; sub_q <= '0; hp_q <= '0; vhp_q <= '0; lc_q <= '0;
      hck_q <= 1'b0; vck_q <= 1'b0;
    end else if (enter) begin
      vact <= 1'b1; sub_q <= '0; hp_q <= '0; vhp_q <= '0; lc_q <= '0;
      hck_q <= 1'b1; vck_q <= 1'b1;
    end else if (vact) begin
      if (last_sub) begin
        sub_q <= '0;
        hck_q <= ~hck_q;
        if (last_hp) begin
          hp_q  <= '0;
          lc_q  <= '0;
          vck_q <= ~vck_q;
          if (last_v) begin
            vact  <= 1'b0;
            hck_q <= 1'b0;
            vck_q <= 1'b0;
            vhp_q <= '0;
          end else begin
            vhp_q <= vhp_q + PW'(1);
          end
        end else begin
          hp_q <= hp_q + PW'(1);
          lc_q <= lc_q + LW'(1);
        end
      end else begin
        sub_q <= sub_q + CW'(1);
        lc_q  <= lc_q + LW'(1);
      end
    end
  end

  // R1
  hck_steady_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    vact && !last_sub |=> $stable(hck_q));

  // R4
  vck_steady_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    vact && !(last_sub && last_hp) |=> $stable(vck_q));
endmodule

// File: rtl/pnl_decode.sv
module pnl_decode
  import pnl_timing_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = CW + 2,
  parameter int LW = 2 * CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          vact,
  input  logic [CW-1:0] sub_q,
  input  logic [PW-1:0] hp_q,
  input  logic [PW-1:0] vhp_q,
  input  logic [LW-1:0] lc_q,
  input  logic [CW-1:0] hck_half,
  input  logic [CW-1:0] hst_delay,
  input  logic [CW-1:0] hst_width,
  input  logic [CW-1:0] h_front,
  input  logic [CW-1:0] h_xfers,
  input  logic [CW-1:0] v_front,
  input  logic [CW-1:0] v_xfers,
  input  logic [CW-1:0] enb_first,
  input  logic [CW-1:0] enb_last,
  input  logic [CW-1:0] enb_start,
  input  logic [CW-1:0] enb_width,
  output logic          hst,
  output logic          enb,
  output logic          stb
);
  logic          xfer_line;
  logic [PW-1:0] line_no;
  logic          line_ok;

  assign xfer_line = in_win(WIN_W'(vhp_q), WIN_W'(v_front), WIN_W'(v_xfers));
  assign line_no   = vhp_q - PW'(v_front);
  assign line_ok   = (line_no >= PW'(enb_first)) && (line_no <= PW'(enb_last));

  assign hst = vact && in_win(WIN_W'(lc_q), WIN_W'(hst_delay), WIN_W'(hst_width));
  assign enb = vact && xfer_line && line_ok &&
               in_win(WIN_W'(hp_q), WIN_W'(enb_start), WIN_W'(enb_width));
  assign stb = vact && xfer_line && (sub_q == '0) &&
               in_win(WIN_W'(hp_q), WIN_W'(h_front), WIN_W'(h_xfers));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    stb && (hck_half >= CW'(2)) |=> !stb);
endmodule

// File: rtl/pnl_timing_gen.sv
module pnl_timing_gen #(
  parameter int CW = 16,
  parameter int FW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          frame_start,
  input  logic [CW-1:0] hck_half,
  input  logic [CW-1:0] rst_width,
  input  logic [CW-1:0] vst_delay,
  input  logic [CW-1:0] vst_width,
  input  logic [CW-1:0] vck_delay,
  input  logic [CW-1:0] hst_delay,
  input  logic [CW-1:0] hst_width,
  input  logic [CW-1:0] h_front,
  input  logic [CW-1:0] h_xfers,
  input  logic [CW-1:0] h_back,
  input  logic [CW-1:0] v_front,
  input  logic [CW-1:0] v_xfers,
  input  logic [CW-1:0] v_back,
  input  logic [CW-1:0] enb_first,
  input  logic [CW-1:0] enb_last,
  input  logic [CW-1:0] enb_start,
  input  logic [CW-1:0] enb_width,
  output logic          pnl_rst,
  output logic          pnl_vst,
  output logic          pnl_vck,
  output logic          pnl_hst,
  output logic          pnl_hck,
  output logic          pnl_enb,
  output logic          xfer_strobe,
  output logic          busy,
  output logic          soft_rst_active
);
  localparam int PW = CW + 2;
  localparam int LW = 2 * CW + 2;

  logic          vact, done, enter;
  logic [CW-1:0] sub_q;
  logic [PW-1:0] hp_q, vhp_q, line_hp, n_vhp;
  logic [LW-1:0] lc_q;

  assign line_hp = PW'(h_front) + PW'(h_xfers) + PW'(h_back);
  assign n_vhp   = PW'(v_front) + PW'(v_xfers) + PW'(v_back);

  pnl_frame_seq #(.CW(CW), .FW(FW)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_start(frame_start),
    .vact(vact), .done(done), .rst_width(rst_width), .vst_delay(vst_delay),
    .vst_width(vst_width), .vck_delay(vck_delay), .busy(busy), .enter(enter),
    .xrst(pnl_rst), .vst(pnl_vst), .srst_flag(soft_rst_active)
  );

  pnl_raster #(.CW(CW), .PW(PW), .LW(LW)) u_raster (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enter(enter),
    .hck_half(hck_half), .line_hp(line_hp), .n_vhp(n_vhp), .vact(vact),
    .sub_q(sub_q), .hp_q(hp_q), .vhp_q(vhp_q), .lc_q(lc_q),
    .hck_q(pnl_hck), .vck_q(pnl_vck), .done(done)
  );

  pnl_decode #(.CW(CW), .PW(PW), .LW(LW)) u_dec (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .vact(vact),
    .sub_q(sub_q), .hp_q(hp_q), .vhp_q(vhp_q), .lc_q(lc_q),
    .hck_half(hck_half), .hst_delay(hst_delay), .hst_width(hst_width),
    .h_front(h_front), .h_xfers(h_xfers), .v_front(v_front), .v_xfers(v_xfers),
    .enb_first(enb_first), .enb_last(enb_last), .enb_start(enb_start),
    .enb_width(enb_width), .hst(pnl_hst), .enb(pnl_enb), .stb(xfer_strobe)
  );

  // R8
  idle_raster_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !busy |-> !vact && !pnl_hck && !pnl_vck);

  // R8
  end_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done |=> !busy);
endmodule

// File: tb/pnl_timing_gen_bench.sv
`timescale 1ns/1ps
module pnl_timing_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic frame_start = 1'b0;
  logic [15:0] hck_half, rst_width, vst_delay, vst_width, vck_delay, hst_delay, hst_width;
  logic [15:0] h_front, h_xfers, h_back, v_front, v_xfers, v_back;
  logic [15:0] enb_first, enb_last, enb_start, enb_width;
  logic pnl_rst, pnl_vst, pnl_vck, pnl_hst, pnl_hck, pnl_enb, xfer_strobe, busy, soft_rst_active;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pnl_timing_gen u_pnl_timing_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_start(frame_start),
    .hck_half(hck_half), .rst_width(rst_width), .vst_delay(vst_delay),
    .vst_width(vst_width), .vck_delay(vck_delay), .hst_delay(hst_delay),
    .hst_width(hst_width), .h_front(h_front), .h_xfers(h_xfers), .h_back(h_back),
    .v_front(v_front), .v_xfers(v_xfers), .v_back(v_back), .enb_first(enb_first),
    .enb_last(enb_last), .enb_start(enb_start), .enb_width(enb_width),
    .pnl_rst(pnl_rst), .pnl_vst(pnl_vst), .pnl_vck(pnl_vck), .pnl_hst(pnl_hst),
    .pnl_hck(pnl_hck), .pnl_enb(pnl_enb), .xfer_strobe(xfer_strobe), .busy(busy),
    .soft_rst_active(soft_rst_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int h, input int xw, input int vsd, input int vsw, input int vd,
                     input int hd, input int hw, input int hf, input int hx, input int hb,
                     input int vf, input int vx, input int vb, input int ef, input int el,
                     input int es, input int ew);
    hck_half = 16'(h); rst_width = 16'(xw); vst_delay = 16'(vsd); vst_width = 16'(vsw);
    vck_delay = 16'(vd); hst_delay = 16'(hd); hst_width = 16'(hw);
    h_front = 16'(hf); h_xfers = 16'(hx); h_back = 16'(hb);
    v_front = 16'(vf); v_xfers = 16'(vx); v_back = 16'(vb);
    enb_first = 16'(ef); enb_last = 16'(el); enb_start = 16'(es); enb_width = 16'(ew);
  endtask

  function automatic int frame_len();
    return int'(vck_delay) + (int'(v_front) + int'(v_xfers) + int'(v_back)) *
           int'(hck_half) * (int'(h_front) + int'(h_xfers) + int'(h_back));
  endfunction

  // expected {rst,vst,vck,hst,hck,enb,strobe,busy} in frame cycle k
  function automatic logic [7:0] model(input int k);
    int h, l, n, m, q, v, p, c, line;
    logic [7:0] e;
    h = int'(hck_half);
    l = int'(h_front) + int'(h_xfers) + int'(h_back);
    n = int'(v_front) + int'(v_xfers) + int'(v_back);
    e = '0;
    if (k < frame_len()) begin
      e[0] = 1'b1;
      e[7] = k < int'(rst_width);
      e[6] = (k >= int'(vst_delay)) && (k < int'(vst_delay) + int'(vst_width));
      if (k >= int'(vck_delay)) begin
        m = k - int'(vck_delay);
        q = m / h; v = q / l; p = q % l; c = m % (h * l);
        line = v - int'(v_front);
        e[5] = (v % 2) == 0;
        e[3] = (q % 2) == 0;
        e[4] = (c >= int'(hst_delay)) && (c < int'(hst_delay) + int'(hst_width));
        if (v >= int'(v_front) && v < int'(v_front) + int'(v_xfers)) begin
          e[1] = (m % h == 0) && p >= int'(h_front) && p < int'(h_front) + int'(h_xfers);
          e[2] = line >= int'(enb_first) && line <= int'(enb_last) &&
                 p >= int'(enb_start) && p < int'(enb_start) + int'(enb_width);
        end
      end
    end
    if (n == 0) e = '0;
    return e;
  endfunction

  // run one frame; raise frame_start again during cycle extra_at (-1: never)
  task automatic play(input int extra_at, input string tag);
    int err[8];
    string nm[8];
    logic [7:0] act, exp;
    int t;
    nm[0] = "R8 busy"; nm[1] = "R6 xfer_strobe"; nm[2] = "R7 pnl_enb"; nm[3] = "R1 pnl_hck";
    nm[4] = "R5 pnl_hst"; nm[5] = "R4 pnl_vck"; nm[6] = "R3 pnl_vst"; nm[7] = "R2 pnl_rst";
    for (int b = 0; b < 8; b++) err[b] = 0;
    t = frame_len();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < t + 4; k++) begin
      act = {pnl_rst, pnl_vst, pnl_vck, pnl_hst, pnl_hck, pnl_enb, xfer_strobe, busy};
      exp = model(k);
      for (int b = 0; b < 8; b++) if (act[b] !== exp[b]) err[b]++;
      frame_start = (k == extra_at);
      @(negedge clk);
    end
    frame_start = 1'b0;
    for (int b = 0; b < 8; b++) check(err[b] == 0, {nm[b], " ", tag}, err[b], 0);
  endtask

  task automatic test_reset();
    check({pnl_rst, pnl_vst, pnl_vck, pnl_hst, pnl_hck, pnl_enb, xfer_strobe, busy,
           soft_rst_active} == '0, "R10 outputs in reset", 1, 0);
  endtask

  task automatic test_frame_a();
    cfg(2, 3, 2, 4, 5, 1, 2, 1, 3, 1, 1, 4, 1, 1, 2, 1, 3);
    play(-1, "frame A");
  endtask

  task automatic test_frame_b();
    cfg(3, 8, 0, 1, 0, 0, 1, 0, 2, 1, 0, 3, 2, 0, 0, 0, 2);
    play(-1, "frame B");
  endtask

  task automatic test_start_while_busy();
    cfg(4, 2, 1, 2, 3, 2, 3, 1, 2, 2, 2, 2, 1, 0, 1, 2, 2);
    play(20, "mid-frame start");
    play(frame_len() - 1, "start at frame end");
  endtask

  task automatic test_soft_reset();
    cfg(2, 3, 2, 4, 5, 1, 2, 1, 3, 1, 1, 4, 1, 1, 2, 1, 3);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (20) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    check({pnl_rst, pnl_vst, pnl_vck, pnl_hst, pnl_hck, pnl_enb, xfer_strobe, busy} == '0,
          "R9 outputs idle under soft reset", int'(busy), 0);
    check(soft_rst_active == 1'b1, "R9 soft_rst_active", int'(soft_rst_active), 1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    soft_rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 start ignored during soft reset", int'(busy), 0);
    check(soft_rst_active == 1'b0, "R9 soft_rst_active clears", int'(soft_rst_active), 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 no late start", int'(busy), 0);
    play(-1, "after soft reset");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cfg(2, 3, 2, 4, 5, 1, 2, 1, 3, 1, 1, 4, 1, 1, 2, 1, 3);
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_frame_a();
    test_frame_b();
    test_start_while_busy();
    test_soft_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule